// File: doc/BRIEF.md
# Dual Programmable Timer with Identification Window

This block places two down-counting timers behind a single 4 KB byte-addressed register window. Each timer occupies a 32-byte slice at the bottom of the window. Reads and writes reach a timer through that slice. The top 32 bytes of the window return a fixed eight-byte identification sequence, one byte per word. Every other location reads as zero and ignores writes. This includes the two test-control words at 0xF00 and 0xF04.

Each timer has its own tick-enable input. This lets the two timers advance at unrelated rates while sharing one system clock. Each timer can further divide its ticks by 16 or 256. A timer runs in one of three modes: free-running, periodic reload, or one-shot. When a timer expires, it latches a pending flag. The flag of each timer is gated by that timer's interrupt enable, and the gated flags of both timers are ORed into one registered interrupt line.

Every read returns its data one clock after the request, together with a one-cycle valid strobe.

Top module: `dual_timer_id`

## Requirements
- R1: A read request (req_valid=1, req_write=0) sampled at a clock edge produces rd_valid=1 and the read data after that same edge. rd_valid is 0 after any edge where no read is requested, including edges that carry a write.
- R2: Byte offsets 0x00–0x1F select timer 0, and offsets 0x20–0x3F select timer 1 at the same local offset. The local offsets are:
  - 0x00: reload value (read/write)
  - 0x04: current count (read only)
  - 0x08: control, 8 bits (read/write)
  - 0x0C: pending clear (write only; reads 0)
  - 0x10: raw pending flag in bit 0
  - 0x14: pending flag ANDed with interrupt enable, in bit 0
  - 0x18: background reload value (read/write)
  - 0x1C: reads 0
- R3: Word offsets 0xFE0, 0xFE4, …, 0xFFC return the bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order. The byte sits in bits 7:0 and all upper bits are zero. Writes to these offsets change nothing.
- R4: Every other offset reads 0, including 0xF00 and 0xF04. Writes outside 0x00–0x3F are ignored. An access whose two low address bits are not zero selects nothing.
- R5: The control bits are:
  - bit 0: one-shot
  - bit 1: 32-bit counting (when 0, the timer counts in 16 bits)
  - bits 3:2: prescale (0 = ÷1, 1 = ÷16, 2 = ÷256, 3 = ÷1)
  - bit 5: interrupt enable
  - bit 6: periodic
  - bit 7: run

  After reset the control register reads 0x20, and the count and reload value read 0.
- R6: While bit 7 is set, each prescaled tick does one of two things:
  - If the count, seen at the selected width, is nonzero, it decrements the count.
  - If the count is zero, it sets the pending flag and then acts by mode. One-shot holds the count at 0 and clears bit 7. Otherwise, periodic reloads the reload value. Otherwise (free-running), the count becomes all ones at the selected width.
- R7: A write to 0x00 sets both the reload value and the count. A write to 0x18 sets only the reload value. In 16-bit mode the count reads with its upper 16 bits as zero.
- R8: A write to the pending-clear offset clears the flag. If an expiry occurs in the same cycle, the expiry wins and the flag stays set.
- R9: irq is a register. After each edge it equals the OR, over both timers, of (pending AND interrupt enable) as they stood before that edge.
- R10: Each timer advances only on its own tick-enable input. Its prescale counter restarts at every control write, so the N-th tick after the write (N = 16 or 256) is the first to count.
- R11: Writes to the current-count offset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_wdata | input | DATA_W | Write data |
| tick_en | input | N_TMR | Per-timer tick enable |
| rd_valid | output | 1 | Read data valid strobe |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Combined interrupt |

## Verification
Two functions of this block can fall in the same cycle, and each such collision is provoked deliberately:
- Expiry with a pending-clear write: the bench brings a periodic timer to a count of zero, then raises its tick enable in the same cycle as a write to the pending-clear offset. It judges the outcome by reading the raw pending flag back as 1 and finding the reloaded count.
- Ticks with the prescale restart: a control write restarts the prescale counter, and the bench counts exactly 15 and 16 (or 255 and 256) ticks after that write to show where the first decrement lands.
- Two timers in the same window: the bench ticks one timer while the other is running, to show the tick inputs do not cross.

// File: rtl/dual_tmr_pkg.sv
package dual_tmr_pkg;
  localparam int CTL_ONESHOT  = 0;
  localparam int CTL_WIDE     = 1;
  localparam int CTL_PRE_LO   = 2;
  localparam int CTL_IE       = 5;
  localparam int CTL_PERIODIC = 6;
  localparam int CTL_RUN      = 7;
  localparam logic [7:0] CTL_RESET = 8'h20;
  localparam int PRESCALE_W = 8;
  localparam int SLICE_W    = 5;

  typedef enum logic [2:0] {
    REG_RELOAD = 3'd0,
    REG_COUNT  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_CLEAR  = 3'd3,
    REG_RAW    = 3'd4,
    REG_MASKED = 3'd5,
    REG_BGLOAD = 3'd6,
    REG_SPARE  = 3'd7
  } treg_e;
endpackage

// File: rtl/tmr_id_rom.sv
module tmr_id_rom (
  input  logic [2:0] idx,
  output logic [7:0] id_byte
);
  always_comb begin
    case (idx)
      3'd0:    id_byte = 8'h04;
      3'd1:    id_byte = 8'h18;
      3'd2:    id_byte = 8'h14;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  end
endmodule

// File: rtl/tmr_decode.sv
module tmr_decode
  import dual_tmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_TMR  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_TMR-1:0]  tmr_hit,
  output treg_e             reg_sel,
  output logic              id_hit,
  output logic [2:0]        id_idx
);
  localparam int SEL_W = ADDR_W - SLICE_W;

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);
  assign reg_sel = treg_e'(addr[4:2]);
  assign id_idx  = addr[4:2];
  assign id_hit  = aligned && (&addr[ADDR_W-1:SLICE_W]);

  for (genvar g = 0; g < N_TMR; g++) begin : g_hit
    assign tmr_hit[g] = aligned && (addr[ADDR_W-1:SLICE_W] == SEL_W'(g));
  end

  always_comb begin
    if (id_hit) assert ((tmr_hit == '0)) else $error("a_r4_decode_exclusive");
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import dual_tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  treg_e             reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_out
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0]     limit_q, count_q, cnt_view, max_val;
  logic [7:0]            ctl_q;
  logic                  pend_q;
  logic [PRESCALE_W-1:0] pre_q;
  logic                  step, run, at_zero, expire, wr_ctl;

  assign wr_ctl = wr_en && (reg_sel == REG_CTRL);

  always_comb begin
    case (ctl_q[CTL_PRE_LO +: 2])
      2'd1:    step = tick_en && (&pre_q[3:0]);
      2'd2:    step = tick_en && (&pre_q);
      default: step = tick_en;
    endcase
  end

  assign cnt_view = ctl_q[CTL_WIDE] ? count_q : {{HALF{1'b0}}, count_q[HALF-1:0]};
  assign max_val  = ctl_q[CTL_WIDE] ? {DATA_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign at_zero  = (cnt_view == '0);
  assign run      = ctl_q[CTL_RUN] && step;
  assign expire   = run && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= '0;
      ctl_q   <= CTL_RESET;
      limit_q <= '0;
      count_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_ctl)       pre_q <= '0;
      else if (tick_en) pre_q <= pre_q + 1'b1;

      if (wr_ctl)                             ctl_q <= wdata[7:0];
      else if (expire && ctl_q[CTL_ONESHOT])  ctl_q[CTL_RUN] <= 1'b0;

      if (wr_en && (reg_sel == REG_RELOAD || reg_sel == REG_BGLOAD))
        limit_q <= wdata;

      if (wr_en && reg_sel == REG_RELOAD) begin
        count_q <= wdata;
      end else if (run) begin
        if (!at_zero)                 count_q <= cnt_view - 1'b1;
        else if (ctl_q[CTL_ONESHOT])  count_q <= cnt_view;
        else if (ctl_q[CTL_PERIODIC]) count_q <= limit_q;
        else                          count_q <= max_val;
      end

      if (expire)                                pend_q <= 1'b1;
      else if (wr_en && reg_sel == REG_CLEAR)    pend_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel)
      REG_RELOAD, REG_BGLOAD: rdata = limit_q;
      REG_COUNT:              rdata = cnt_view;
      REG_CTRL:               rdata = {{(DATA_W-8){1'b0}}, ctl_q};
      REG_RAW:                rdata = {{(DATA_W-1){1'b0}}, pend_q};
      REG_MASKED:             rdata = {{(DATA_W-1){1'b0}}, pend_q & ctl_q[CTL_IE]};
      default:                rdata = '0;
    endcase
  end

  assign irq_out = pend_q & ctl_q[CTL_IE];

  // R6: expiry always leaves the pending flag set
  a_r6_expire_sets_pend: assert property (@(posedge clk) disable iff (rst)
    expire |=> pend_q);
  // R6: a one-shot expiry stops the timer unless control is rewritten
  a_r6_oneshot_halts: assert property (@(posedge clk) disable iff (rst)
    (expire && ctl_q[CTL_ONESHOT] && !wr_ctl) |=> !ctl_q[CTL_RUN]);
  // R8: clear without a concurrent expiry drops the flag
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == REG_CLEAR && !expire) |=> !pend_q);
  // R11: the count holds when only its own offset is written
  a_r11_count_ro: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == REG_COUNT && !run) |=> $stable(count_q));
endmodule

// File: rtl/dual_timer_id.sv
module dual_timer_id
  import dual_tmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int N_TMR  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [N_TMR-1:0]  tick_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [N_TMR-1:0]  tmr_hit;
  treg_e             reg_sel;
  logic              id_hit;
  logic [2:0]        id_idx;
  logic [7:0]        id_byte;
  logic [DATA_W-1:0] t_rdata [N_TMR];
  logic [N_TMR-1:0]  t_irq;
  logic [DATA_W-1:0] rd_next;
  logic              rd_req, wr_req;

  assign rd_req = req_valid && !req_write;
  assign wr_req = req_valid && req_write;

  tmr_decode #(.ADDR_W(ADDR_W), .N_TMR(N_TMR)) u_decode (
    .addr(req_addr), .tmr_hit(tmr_hit), .reg_sel(reg_sel),
    .id_hit(id_hit), .id_idx(id_idx)
  );

  tmr_id_rom u_id (.idx(id_idx), .id_byte(id_byte));

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    tmr_core #(.DATA_W(DATA_W)) u_core (
      .clk(clk), .rst(rst), .tick_en(tick_en[g]),
      .wr_en(wr_req && tmr_hit[g]), .reg_sel(reg_sel), .wdata(req_wdata),
      .rdata(t_rdata[g]), .irq_out(t_irq[g])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < N_TMR; i++)
      if (tmr_hit[i]) rd_next = t_rdata[i];
    if (id_hit) rd_next = {{(DATA_W-8){1'b0}}, id_byte};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      irq      <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_next;
      irq <= |t_irq;
    end
  end

  // R1: read strobe follows each read request by one edge
  a_r1_read_strobe: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  a_r1_no_spurious_strobe: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);
  // R3: identification words carry only a byte
  a_r3_id_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_req && id_hit) |=> (rd_data[DATA_W-1:8] == '0));
  // R4: unmapped reads return zero
  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !id_hit && tmr_hit == '0) |=> (rd_data == '0));
  // R9: combined interrupt tracks the timers one edge later
  a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (|t_irq) |=> irq);
  a_r9_irq_fall: assert property (@(posedge clk) disable iff (rst)
    !(|t_irq) |=> !irq);
endmodule

// File: tb/dual_timer_id_tb.sv
module dual_timer_id_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  tick_en = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  localparam logic [11:0] T0 = 12'h000, T1 = 12'h020;
  localparam logic [11:0] O_LD = 12'h00, O_VAL = 12'h04, O_CTL = 12'h08,
                          O_CLR = 12'h0C, O_RAW = 12'h10, O_MSK = 12'h14, O_BG = 12'h18;

  always #5 clk = ~clk;

  dual_timer_id dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .tick_en(tick_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [31:0] id_exp(int i);
    case (i)
      0: return 32'h04; 1: return 32'h18; 2: return 32'h14; 3: return 32'h00;
      4: return 32'h0D; 5: return 32'hF0; 6: return 32'h05; default: return 32'hB1;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    if (!rd_valid) begin
      n_fail++;
      $display("FAIL R1: actual rd_valid 0 expected 1 at %h", a);
    end
    d = rd_data;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic tick(logic [1:0] m, int n);
    repeat (n) begin
      @(negedge clk); tick_en = m;
      @(negedge clk); tick_en = '0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R9 reset irq", {31'b0, irq}, 32'h0);
    chk("R1 reset rd_valid", {31'b0, rd_valid}, 32'h0);
    rd_chk("R5 reset ctl t0", T0 + O_CTL, 32'h20);
    rd_chk("R5 reset ctl t1", T1 + O_CTL, 32'h20);
    rd_chk("R5 reset count", T1 + O_VAL, 32'h0);

    wr(T0 + O_BG, 32'h1);
    chk("R1 no strobe on write", {31'b0, rd_valid}, 32'h0);

    // R3 identification table, directed then random
    for (int i = 0; i < 8; i++) rd_chk("R3 id", 12'hFE0 + 12'(i * 4), id_exp(i));
    for (int k = 0; k < 16; k++) begin
      int i = int'($urandom % 8);
      rd_chk("R3 id random", 12'hFE0 + 12'(i * 4), id_exp(i));
    end
    wr(12'hFE8, 32'hFFFF_FFFF);
    rd_chk("R3 id write ignored", 12'hFE8, 32'h14);

    // R4 test words, misaligned, unmapped
    rd_chk("R4 test ctl", 12'hF00, 32'h0);
    rd_chk("R4 test out", 12'hF04, 32'h0);
    rd_chk("R4 misaligned", 12'h018 | 12'h1, 32'h0);
    for (int k = 0; k < 20; k++) begin
      logic [11:0] a = (12'h040 + 12'($urandom % (12'hFE0 - 12'h040))) & 12'hFFC;
      rd_chk("R4 unmapped read", a, 32'h0);
    end

    // R2 random reload/background readback with interleaved stray writes (R4)
    for (int k = 0; k < 12; k++) begin
      logic [31:0] v0 = $urandom, v1 = $urandom;
      logic [11:0] a = (12'h040 + 12'($urandom % 12'hF00)) & 12'hFFC;
      wr(T0 + O_LD, v0);
      wr(T1 + O_BG, v1);
      wr(a, ~v0);
      wr(12'h000 | 12'h2, 32'h0);
      rd_chk("R2 t0 reload", T0 + O_LD, v0);
      rd_chk("R2 t1 bgload", T1 + O_BG, v1);
      rd_chk("R2 t0 count", T0 + O_VAL, {16'h0, v0[15:0]});
    end
    rd_chk("R2 spare offset", T0 + 12'h1C, 32'h0);
    rd_chk("R2 clear offset reads 0", T0 + O_CLR, 32'h0);

    // R6 periodic 32-bit with interrupt enable
    wr(T0 + O_LD, 32'd3);
    wr(T0 + O_CTL, 32'hE2);
    tick(2'b01, 3);
    rd_chk("R6 count reaches 0", T0 + O_VAL, 32'd0);
    rd_chk("R6 no pend before expiry", T0 + O_RAW, 32'd0);
    tick(2'b01, 1);
    rd_chk("R6 expiry pend", T0 + O_RAW, 32'd1);
    chk("R9 irq on", {31'b0, irq}, 32'h1);
    rd_chk("R6 periodic reload", T0 + O_VAL, 32'd3);
    rd_chk("R2 masked", T0 + O_MSK, 32'd1);

    // R8 clear
    wr(T0 + O_CLR, 32'h0);
    rd_chk("R8 cleared", T0 + O_RAW, 32'd0);
    chk("R9 irq off", {31'b0, irq}, 32'h0);

    // R8 collision: expiry and clear in the same cycle
    wr(T0 + O_LD, 32'd1);
    tick(2'b01, 1);
    @(negedge clk);
    tick_en = 2'b01; req_valid = 1; req_write = 1; req_addr = T0 + O_CLR;
    @(negedge clk);
    tick_en = 0; req_valid = 0; req_write = 0;
    rd_chk("R8 expiry beats clear", T0 + O_RAW, 32'd1);
    rd_chk("R8 reload on collision", T0 + O_VAL, 32'd1);

    // R11 count not writable
    wr(T0 + O_VAL, 32'h55);
    rd_chk("R11 count write ignored", T0 + O_VAL, 32'd1);

    // timer0 running without IE, count 5
    wr(T0 + O_CTL, 32'hC2);
    wr(T0 + O_CLR, 32'h0);
    wr(T0 + O_LD, 32'd5);

    // R6 one-shot on timer1, R10 timer0 unaffected
    wr(T1 + O_LD, 32'd2);
    wr(T1 + O_CTL, 32'hA3);
    tick(2'b10, 3);
    rd_chk("R6 oneshot run cleared", T1 + O_CTL, 32'h23);
    rd_chk("R6 oneshot pend", T1 + O_RAW, 32'd1);
    chk("R9 irq from timer1", {31'b0, irq}, 32'h1);
    tick(2'b10, 2);
    rd_chk("R6 oneshot holds 0", T1 + O_VAL, 32'd0);
    rd_chk("R10 timer0 untouched", T0 + O_VAL, 32'd5);

    // R6 free-running 16-bit, IE off
    wr(T1 + O_CLR, 32'h0);
    wr(T1 + O_LD, 32'd1);
    wr(T1 + O_CTL, 32'h80);
    tick(2'b10, 2);
    rd_chk("R6 freerun 16 wrap", T1 + O_VAL, 32'h0000FFFF);
    rd_chk("R6 freerun pend", T1 + O_RAW, 32'd1);
    rd_chk("R2 masked off", T1 + O_MSK, 32'd0);
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    tick(2'b10, 1);
    rd_chk("R6 freerun dec", T1 + O_VAL, 32'h0000FFFE);
    wr(T1 + O_LD, 32'd0);
    wr(T1 + O_CTL, 32'h82);
    tick(2'b10, 1);
    rd_chk("R6 freerun 32 wrap", T1 + O_VAL, 32'hFFFFFFFF);

    // R7 width view and background reload
    wr(T1 + O_CTL, 32'h00);
    wr(T1 + O_LD, 32'h12340002);
    rd_chk("R7 16-bit view", T1 + O_VAL, 32'h00000002);
    rd_chk("R7 reload full", T1 + O_LD, 32'h12340002);
    wr(T1 + O_LD, 32'd1);
    wr(T1 + O_BG, 32'd7);
    wr(T1 + O_CTL, 32'hC2);
    rd_chk("R7 bgload keeps count", T1 + O_VAL, 32'd1);
    tick(2'b10, 2);
    rd_chk("R7 bgload used at reload", T1 + O_VAL, 32'd7);

    // R10 prescale restart at control write
    wr(T0 + O_LD, 32'd1);
    wr(T0 + O_CTL, 32'hC4);
    tick(2'b01, 15);
    rd_chk("R10 div16 before", T0 + O_VAL, 32'd1);
    tick(2'b01, 1);
    rd_chk("R10 div16 step", T0 + O_VAL, 32'd0);
    wr(T0 + O_LD, 32'd1);
    wr(T0 + O_CTL, 32'hC8);
    tick(2'b01, 255);
    rd_chk("R10 div256 before", T0 + O_VAL, 32'd1);
    tick(2'b01, 1);
    rd_chk("R10 div256 step", T0 + O_VAL, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule